// File: doc/BRIEF.md
# Bus Access Policy Firewall

This block sits on the path between a memory-mapped system bus master (AXI-Lite style channels) and one peripheral. It checks every access against a static policy. The policy has a direction permission, a largest allowed transfer width, an error-code enable and a permitted requester ID. An access that meets the policy is passed through unchanged, and the peripheral's response and read data are returned to the master.

A write that breaks the policy is dropped, and the master still gets a normal completion. A read that breaks the policy never reaches the peripheral. It is answered with an error response and with either a designer-chosen substitute word or zero. Every blocked access sends a one-cycle pulse to a monitor.

A blocked access also raises the protection level. The level becomes fully locked when error-code mode is set, and read-only when it is not. The level drops back to open once a programmable number of cycles passes with no further violation. The requester identity comes from a small ID register. A master writes this register at a reserved address just before its real transaction.

Top module: `fw_bus_guard`

## Requirements
- R1: After reset no valid is driven on either side, the attack output is low, the protection level is open and the requester ID register holds 0.
- R2: Access field `cfg_access`: bit 0 grants reads and bit 1 grants writes (00 none, 01 read only, 10 write only, 11 both).
- R3: Width field `cfg_width` and the transfer size codes `s_awsize`/`s_arsize` use 00=4, 01=8, 10=16 and 11=32 bits. An access is allowed only when its size code is not above `cfg_width`.
- R4: A write to address `ID_ADDR` loads `s_wdata[ID_W-1:0]` into the requester ID register. It is never forwarded, always completes with OKAY (00) and is never a violation.
- R5: An access is blocked whenever the requester ID register differs from `cfg_allowed_id`.
- R6: A permitted access is forwarded once to the peripheral. The peripheral's write response, read response and read data are returned to the master unchanged.
- R7: A blocked write is not forwarded, and the master receives `s_bvalid` with response OKAY (00).
- R8: A blocked read is not forwarded and returns response SLVERR (10). The data is `cfg_subst` when `cfg_errmode` is 1 and zero when it is 0.
- R9: Each blocked access raises `attack` for exactly one cycle, in the cycle after the accepting clock edge.
- R10: A violation while `cfg_errmode` is 1 moves the block to the locked level, where every access except an ID-register write is blocked.
- R11: A violation while `cfg_errmode` is 0 moves the block to the read-only level. At that level writes are blocked and reads are still judged by the policy.
- R12: From the locked or read-only level, the block returns to open after `cfg_quiet` consecutive cycles without a violation (0 is treated as 1). An access blocked only because of the raised level counts as a violation and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_access | input | 2 | Direction permission field |
| cfg_width | input | 2 | Largest allowed transfer size code |
| cfg_errmode | input | 1 | Error-code mode enable |
| cfg_allowed_id | input | ID_W | Permitted requester ID |
| cfg_quiet | input | CNT_W | Violation-free cycles before returning to open |
| cfg_subst | input | DATA_W | Substitute read word in error-code mode |
| s_awvalid | input | 1 | Master write address valid |
| s_awready | output | 1 | Master write address ready |
| s_awaddr | input | ADDR_W | Master write address |
| s_awsize | input | 2 | Master write size code |
| s_wvalid | input | 1 | Master write data valid |
| s_wready | output | 1 | Master write data ready |
| s_wdata | input | DATA_W | Master write data |
| s_wstrb | input | DATA_W/8 | Master write byte strobes |
| s_bvalid | output | 1 | Write response valid to master |
| s_bready | input | 1 | Master write response ready |
| s_bresp | output | 2 | Write response to master |
| s_arvalid | input | 1 | Master read address valid |
| s_arready | output | 1 | Master read address ready |
| s_araddr | input | ADDR_W | Master read address |
| s_arsize | input | 2 | Master read size code |
| s_rvalid | output | 1 | Read data valid to master |
| s_rready | input | 1 | Master read data ready |
| s_rdata | output | DATA_W | Read data to master |
| s_rresp | output | 2 | Read response to master |
| m_awvalid | output | 1 | Peripheral write address valid |
| m_awready | input | 1 | Peripheral write address ready |
| m_awaddr | output | ADDR_W | Peripheral write address |
| m_wvalid | output | 1 | Peripheral write data valid |
| m_wready | input | 1 | Peripheral write data ready |
| m_wdata | output | DATA_W | Peripheral write data |
| m_wstrb | output | DATA_W/8 | Peripheral write strobes |
| m_bvalid | input | 1 | Peripheral write response valid |
| m_bready | output | 1 | Peripheral write response ready |
| m_bresp | input | 2 | Peripheral write response |
| m_arvalid | output | 1 | Peripheral read address valid |
| m_arready | input | 1 | Peripheral read address ready |
| m_araddr | output | ADDR_W | Peripheral read address |
| m_rvalid | input | 1 | Peripheral read data valid |
| m_rready | output | 1 | Peripheral read data ready |
| m_rdata | input | DATA_W | Peripheral read data |
| m_rresp | input | 2 | Peripheral read response |
| attack | output | 1 | One-cycle violation pulse to the monitor |

## Verification
The attack pulse is due exactly one cycle after the clock edge that accepts the request. The bench samples it at the falling edge right after that acceptance edge, and once more one cycle later to confirm it has cleared. Responses have no fixed latency, so the bench follows the valid/ready handshake at falling edges and reads the response and data only in a cycle where valid is high. Level changes are judged from accept edges: a request issued well inside the quiet window must be blocked, and one issued well past it must pass. A near-exhaustive sweep covers every combination of access field, width field and size code for both directions, with the expected outcome computed from R2 and R3.

// File: rtl/fw_guard_pkg.sv
package fw_guard_pkg;
  typedef enum logic [1:0] {LVL_OPEN, LVL_RDONLY, LVL_LOCKED} lvl_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WFWD, ST_WBWAIT, ST_BRESP, ST_RFWD, ST_RWAIT, ST_RRESP
  } st_e;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/fw_rule_check.sv
module fw_rule_check
  import fw_guard_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic [1:0]      cfg_access,
  input  logic [1:0]      cfg_width,
  input  logic [ID_W-1:0] cfg_allowed_id,
  input  logic [ID_W-1:0] id_q,
  input  lvl_e            level,
  input  logic            is_write,
  input  logic [1:0]      xfer_size,
  output logic            permit
);
  logic dir_ok, size_ok, id_ok, lvl_ok;

  always_comb begin
    dir_ok  = is_write ? cfg_access[1] : cfg_access[0];
    size_ok = (xfer_size <= cfg_width);
    id_ok   = (id_q == cfg_allowed_id);
    lvl_ok  = (level == LVL_OPEN) || ((level == LVL_RDONLY) && !is_write);
    permit  = dir_ok && size_ok && id_ok && lvl_ok;
  end
endmodule

// File: rtl/fw_protect_level.sv
module fw_protect_level
  import fw_guard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             viol,
  input  logic             errmode,
  input  logic [CNT_W-1:0] quiet,
  output lvl_e             level,
  output logic             attack
);
  lvl_e             level_q, level_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             cnt_en;

  always_comb begin
    level_d = level_q;
    cnt_d   = cnt_q;
    cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    cnt_en  = viol || (level_q != LVL_OPEN);
    if (viol) begin
      level_d = errmode ? LVL_LOCKED : LVL_RDONLY;
      cnt_d   = '0;
    end else if (level_q != LVL_OPEN) begin
      if (cnt_inc >= {1'b0, quiet}) begin
        level_d = LVL_OPEN;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LVL_OPEN;
      cnt_q   <= '0;
      attack  <= 1'b0;
    end else begin
      attack <= viol;
      if (cnt_en) begin
        level_q <= level_d;
        cnt_q   <= cnt_d;
      end
    end
  end

  assign level = level_q;

  assert_lock_on_viol_R10: assert property (@(posedge clk) disable iff (!rst_n)
    viol && errmode |=> level_q == LVL_LOCKED);
  assert_rdonly_on_viol_R11: assert property (@(posedge clk) disable iff (!rst_n)
    viol && !errmode |=> level_q == LVL_RDONLY);
  assert_open_stays_R12: assert property (@(posedge clk) disable iff (!rst_n)
    level_q == LVL_OPEN && !viol |=> level_q == LVL_OPEN);
endmodule

// File: rtl/fw_txn_ctrl.sv
module fw_txn_ctrl
  import fw_guard_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              DATA_W  = 32,
  parameter int              ID_W    = 4,
  parameter logic [ADDR_W-1:0] ID_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              permit,
  input  logic              errmode,
  input  logic [DATA_W-1:0] subst,
  output logic              is_write,
  output logic              viol,
  output logic [ID_W-1:0]   id_q,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp
);
  localparam int STRB_W = DATA_W / 8;

  st_e               st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d, rdata_q, rdata_d;
  logic [STRB_W-1:0] wstrb_q, wstrb_d;
  logic [1:0]        resp_q, resp_d;
  logic              aw_done_q, aw_done_d, w_done_q, w_done_d;
  logic [ID_W-1:0]   id_d;
  logic              wr_req, rd_req, idle, acc_wr, acc_rd, id_hit;

  always_comb begin
    wr_req   = s_awvalid && s_wvalid;
    rd_req   = s_arvalid && !wr_req;
    idle     = (st_q == ST_IDLE);
    acc_wr   = idle && wr_req;
    acc_rd   = idle && rd_req;
    id_hit   = (s_awaddr == ID_ADDR);
    is_write = wr_req;
    viol     = (acc_wr && !id_hit && !permit) || (acc_rd && !permit);
  end

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    wstrb_d   = wstrb_q;
    rdata_d   = rdata_q;
    resp_d    = resp_q;
    aw_done_d = aw_done_q;
    w_done_d  = w_done_q;
    id_d      = id_q;
    unique case (st_q)
      ST_IDLE: begin
        if (acc_wr) begin
          addr_d  = s_awaddr;
          wdata_d = s_wdata;
          wstrb_d = s_wstrb;
          resp_d  = RESP_OKAY;
          if (id_hit) begin
            id_d = s_wdata[ID_W-1:0];
            st_d = ST_BRESP;
          end else if (permit) begin
            aw_done_d = 1'b0;
            w_done_d  = 1'b0;
            st_d      = ST_WFWD;
          end else begin
            st_d = ST_BRESP;
          end
        end else if (acc_rd) begin
          addr_d = s_araddr;
          if (permit) begin
            st_d = ST_RFWD;
          end else begin
            resp_d  = RESP_SLVERR;
            rdata_d = errmode ? subst : '0;
            st_d    = ST_RRESP;
          end
        end
      end
      ST_WFWD: begin
        aw_done_d = aw_done_q || m_awready;
        w_done_d  = w_done_q || m_wready;
        if (aw_done_d && w_done_d) st_d = ST_WBWAIT;
      end
      ST_WBWAIT: begin
        if (m_bvalid) begin
          resp_d = m_bresp;
          st_d   = ST_BRESP;
        end
      end
      ST_BRESP: if (s_bready) st_d = ST_IDLE;
      ST_RFWD:  if (m_arready) st_d = ST_RWAIT;
      ST_RWAIT: begin
        if (m_rvalid) begin
          rdata_d = m_rdata;
          resp_d  = m_rresp;
          st_d    = ST_RRESP;
        end
      end
      ST_RRESP: if (s_rready) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      wstrb_q   <= '0;
      rdata_q   <= '0;
      resp_q    <= RESP_OKAY;
      aw_done_q <= 1'b0;
      w_done_q  <= 1'b0;
      id_q      <= '0;
    end else begin
      st_q      <= st_d;
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
      wstrb_q   <= wstrb_d;
      rdata_q   <= rdata_d;
      resp_q    <= resp_d;
      aw_done_q <= aw_done_d;
      w_done_q  <= w_done_d;
      id_q      <= id_d;
    end
  end

  always_comb begin
    s_awready = acc_wr;
    s_wready  = acc_wr;
    s_arready = acc_rd;
    s_bvalid  = (st_q == ST_BRESP);
    s_bresp   = resp_q;
    s_rvalid  = (st_q == ST_RRESP);
    s_rresp   = resp_q;
    s_rdata   = rdata_q;
    m_awvalid = (st_q == ST_WFWD) && !aw_done_q;
    m_wvalid  = (st_q == ST_WFWD) && !w_done_q;
    m_awaddr  = addr_q;
    m_wdata   = wdata_q;
    m_wstrb   = wstrb_q;
    m_bready  = (st_q == ST_WBWAIT);
    m_arvalid = (st_q == ST_RFWD);
    m_araddr  = addr_q;
    m_rready  = (st_q == ST_RWAIT);
  end

  assert_blocked_write_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && !id_hit && !permit |=> s_bvalid && !m_awvalid && s_bresp == RESP_OKAY);
  assert_blocked_read_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && !permit |=> s_rvalid && !m_arvalid && s_rresp == RESP_SLVERR);
  assert_id_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && id_hit |=> id_q == $past(s_wdata[ID_W-1:0]) && s_bvalid && !m_awvalid);
  assert_bvalid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));
  assert_rvalid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
endmodule

// File: rtl/fw_bus_guard.sv
module fw_bus_guard
  import fw_guard_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter int                DATA_W  = 32,
  parameter int                ID_W    = 4,
  parameter int                CNT_W   = 16,
  parameter logic [ADDR_W-1:0] ID_ADDR = 16'hFFFC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_access,
  input  logic [1:0]          cfg_width,
  input  logic                cfg_errmode,
  input  logic [ID_W-1:0]     cfg_allowed_id,
  input  logic [CNT_W-1:0]    cfg_quiet,
  input  logic [DATA_W-1:0]   cfg_subst,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [1:0]          s_awsize,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [1:0]          s_bresp,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic [1:0]          s_arsize,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [1:0]          m_bresp,
  output logic                m_arvalid,
  input  logic                m_arready,
  output logic [ADDR_W-1:0]   m_araddr,
  input  logic                m_rvalid,
  output logic                m_rready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  output logic                attack
);
  logic [1:0]      rst_pipe;
  logic            rst_ni;
  logic            permit, is_write, viol;
  logic [ID_W-1:0] id_q;
  logic [1:0]      xfer_size;
  lvl_e            level;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni    = rst_pipe[1];
  assign xfer_size = is_write ? s_awsize : s_arsize;

  fw_rule_check #(.ID_W(ID_W)) u_rule (
    .cfg_access(cfg_access), .cfg_width(cfg_width), .cfg_allowed_id(cfg_allowed_id),
    .id_q(id_q), .level(level), .is_write(is_write), .xfer_size(xfer_size),
    .permit(permit)
  );

  fw_protect_level #(.CNT_W(CNT_W)) u_level (
    .clk(clk), .rst_n(rst_ni), .viol(viol), .errmode(cfg_errmode),
    .quiet(cfg_quiet), .level(level), .attack(attack)
  );

  fw_txn_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .ID_ADDR(ID_ADDR)) u_txn (
    .clk(clk), .rst_n(rst_ni), .permit(permit), .errmode(cfg_errmode), .subst(cfg_subst),
    .is_write(is_write), .viol(viol), .id_q(id_q),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp)
  );

  assert_attack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    attack |=> !attack);
  assert_attack_after_viol_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    viol |=> attack);
endmodule

// File: tb/fw_bus_guard_bench.sv
module fw_bus_guard_bench;
  localparam int CLK_P = 10;
  localparam logic [15:0] ID_A = 16'hFFFC;

  logic clk, rst_n;
  logic [1:0] cfg_access, cfg_width;
  logic cfg_errmode;
  logic [3:0] cfg_allowed_id;
  logic [15:0] cfg_quiet;
  logic [31:0] cfg_subst;
  logic s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid, s_bready;
  logic [15:0] s_awaddr, s_araddr, m_awaddr, m_araddr;
  logic [1:0] s_awsize, s_arsize, s_bresp, s_rresp;
  logic [31:0] s_wdata, s_rdata, m_wdata;
  logic [3:0] s_wstrb, m_wstrb;
  logic s_arvalid, s_arready, s_rvalid, s_rready;
  logic m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, attack;
  logic p_bvalid, p_rvalid;
  logic [31:0] p_rdata;
  logic [31:0] pmem [16];
  logic [31:0] shadow [16];
  int wr_cnt;
  int n_tests = 0, n_fail = 0;

  fw_bus_guard u_fw_bus_guard (
    .clk(clk), .rst_n(rst_n), .cfg_access(cfg_access), .cfg_width(cfg_width),
    .cfg_errmode(cfg_errmode), .cfg_allowed_id(cfg_allowed_id), .cfg_quiet(cfg_quiet),
    .cfg_subst(cfg_subst),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awsize(s_awsize),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arsize(s_arsize),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .m_awvalid(m_awvalid), .m_awready(1'b1), .m_awaddr(m_awaddr),
    .m_wvalid(m_wvalid), .m_wready(1'b1), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_bvalid(p_bvalid), .m_bready(m_bready), .m_bresp(2'b00),
    .m_arvalid(m_arvalid), .m_arready(1'b1), .m_araddr(m_araddr),
    .m_rvalid(p_rvalid), .m_rready(m_rready), .m_rdata(p_rdata), .m_rresp(2'b00),
    .attack(attack)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // peripheral model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) pmem[i] <= '0;
      wr_cnt <= 0; p_bvalid <= 1'b0; p_rvalid <= 1'b0; p_rdata <= '0;
    end else begin
      if (m_awvalid && m_wvalid) begin
        pmem[m_awaddr[5:2]] <= m_wdata;
        wr_cnt <= wr_cnt + 1;
        p_bvalid <= 1'b1;
      end else if (p_bvalid && m_bready) p_bvalid <= 1'b0;
      if (m_arvalid) begin
        p_rdata <= pmem[m_araddr[5:2]];
        p_rvalid <= 1'b1;
      end else if (p_rvalid && m_rready) p_rvalid <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input logic [1:0] sz,
                           output logic [1:0] resp, output logic a1, output logic a2);
    @(negedge clk);
    s_awvalid = 1'b1; s_awaddr = a; s_awsize = sz; s_wvalid = 1'b1; s_wdata = d; s_wstrb = 4'hF;
    #1;
    while (!s_awready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0; a1 = attack;
    @(negedge clk); a2 = attack; s_bready = 1'b1; #1;
    while (!s_bvalid) begin @(negedge clk); #1; end
    resp = s_bresp;
    @(posedge clk); @(negedge clk); s_bready = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [1:0] sz, output logic [31:0] d,
                          output logic [1:0] resp, output logic a1, output logic a2);
    @(negedge clk);
    s_arvalid = 1'b1; s_araddr = a; s_arsize = sz;
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    s_arvalid = 1'b0; a1 = attack;
    @(negedge clk); a2 = attack; s_rready = 1'b1; #1;
    while (!s_rvalid) begin @(negedge clk); #1; end
    resp = s_rresp; d = s_rdata;
    @(posedge clk); @(negedge clk); s_rready = 1'b0;
  endtask

  task automatic wr_chk(input string tag, input logic [15:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input logic exp_fwd, input logic exp_atk);
    logic [1:0] r; logic a1, a2; int c0;
    c0 = wr_cnt;
    bus_write(a, d, sz, r, a1, a2);
    chk({tag, " bresp"}, {30'd0, r}, 32'd0);
    chk({tag, " forwarded"}, wr_cnt - c0, {31'd0, exp_fwd});
    chk({tag, " attack"}, {31'd0, a1}, {31'd0, exp_atk});
    chk({tag, " R9 pulse cleared"}, {31'd0, a2}, 32'd0);
    if (exp_fwd) shadow[a[5:2]] = d;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [1:0] sz,
                        input logic exp_pass, input logic [31:0] blk_data);
    logic [1:0] r; logic a1, a2; logic [31:0] d;
    bus_read(a, sz, d, r, a1, a2);
    chk({tag, " rresp"}, {30'd0, r}, exp_pass ? 32'd0 : 32'd2);
    chk({tag, " rdata"}, d, exp_pass ? shadow[a[5:2]] : blk_data);
    chk({tag, " attack"}, {31'd0, a1}, {31'd0, !exp_pass});
    chk({tag, " R9 pulse cleared"}, {31'd0, a2}, 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    rst_n = 1'b0;
    s_awvalid = 0; s_awaddr = 0; s_awsize = 0; s_wvalid = 0; s_wdata = 0; s_wstrb = 0;
    s_bready = 0; s_arvalid = 0; s_araddr = 0; s_arsize = 0; s_rready = 0;
    cfg_access = 2'b11; cfg_width = 2'b11; cfg_errmode = 1'b1; cfg_allowed_id = 4'd0;
    cfg_quiet = 16'd1; cfg_subst = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 s_bvalid", {31'd0, s_bvalid}, 0);
    chk("R1 s_rvalid", {31'd0, s_rvalid}, 0);
    chk("R1 m_awvalid", {31'd0, m_awvalid}, 0);
    chk("R1 m_arvalid", {31'd0, m_arvalid}, 0);
    chk("R1 attack", {31'd0, attack}, 0);
    // R1: ID register is 0 and level open, so a write with allowed id 0 passes (R6)
    wr_chk("R1/R6 write after reset", 16'h0004, 32'h1234_5678, 2'b11, 1, 0);
    rd_chk("R6 read back", 16'h0004, 2'b11, 1, 0);

    // R4: ID register write
    cfg_allowed_id = 4'd5;
    wr_chk("R4 id write", ID_A, 32'hFFFF_FF05, 2'b11, 0, 0);
    wr_chk("R6 write with id 5", 16'h0008, 32'hA5A5_0001, 2'b10, 1, 0);

    // R2/R3: sweep access, width and size for both directions (error mode on, quiet 1)
    for (int ac = 0; ac < 4; ac++)
      for (int wd = 0; wd < 4; wd++)
        for (int sz = 0; sz < 4; sz++) begin
          logic wok, rok;
          cfg_access = ac[1:0]; cfg_width = wd[1:0];
          wok = ac[1] && (sz <= wd);
          rok = ac[0] && (sz <= wd);
          wr_chk($sformatf("R2/R3/R7 wr ac=%0d wd=%0d sz=%0d", ac, wd, sz),
                 16'h0008, {ac[7:0], wd[7:0], sz[7:0], 8'h3C}, sz[1:0], wok, !wok);
          rd_chk($sformatf("R2/R3/R8 rd ac=%0d wd=%0d sz=%0d", ac, wd, sz),
                 16'h0008, sz[1:0], rok, 32'hDEAD_BEEF);
        end

    // R5: requester id mismatch
    cfg_access = 2'b11; cfg_width = 2'b11;
    wr_chk("R4 id write mismatch value", ID_A, 32'h0000_0003, 2'b00, 0, 0);
    wr_chk("R5 write wrong id", 16'h000C, 32'h0BAD_0BAD, 2'b11, 0, 1);
    rd_chk("R5 read wrong id", 16'h000C, 2'b11, 0, 32'hDEAD_BEEF);
    wr_chk("R4 id write restore", ID_A, 32'h0000_0005, 2'b00, 0, 0);
    wr_chk("R5 write right id", 16'h000C, 32'h600D_600D, 2'b11, 1, 0);

    // R10/R12: locked level after a violation in error mode
    cfg_quiet = 16'd30; cfg_access = 2'b01; cfg_errmode = 1'b1;
    wr_chk("R10 violating write", 16'h000C, 32'h1111_1111, 2'b11, 0, 1);
    rd_chk("R10 legal read while locked", 16'h000C, 2'b11, 0, 32'hDEAD_BEEF);
    repeat (10) @(negedge clk);
    rd_chk("R12 read inside restarted window", 16'h000C, 2'b11, 0, 32'hDEAD_BEEF);
    repeat (40) @(negedge clk);
    rd_chk("R12 read after quiet window", 16'h000C, 2'b11, 1, 0);

    // R11/R12: read-only level when error mode is off
    cfg_errmode = 1'b0; cfg_access = 2'b11; cfg_width = 2'b00;
    wr_chk("R3 oversize write", 16'h0010, 32'h2222_2222, 2'b10, 0, 1);
    wr_chk("R11 legal write at read-only level", 16'h0010, 32'h3333_3333, 2'b00, 0, 1);
    rd_chk("R11 legal read at read-only level", 16'h000C, 2'b00, 1, 0);
    repeat (40) @(negedge clk);
    wr_chk("R12 write after read-only window", 16'h0010, 32'h4444_4444, 2'b00, 1, 0);
    rd_chk("R6 read forwarded data", 16'h0010, 2'b00, 1, 0);

    // R8: blocked read without error mode returns zero
    cfg_access = 2'b10;
    rd_chk("R8 blocked read zero data", 16'h0010, 2'b00, 0, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule